// File: doc/BRIEF.md
# Isochronous OUT Endpoint Receive Controller

This block runs the receive side of one device-mode isochronous OUT endpoint. A link layer delivers each packet as a burst of byte beats. The last beat is marked, and a flag on any beat reports a bad CRC. The block stores accepted packets in slot memory that holds one packet, or two when the double-buffer configuration input is high.

Software sees the endpoint through four things:
- a 16-bit control/status word;
- a maximum-packet-size register;
- a byte count for the packet at the head of the queue;
- a valid/ready unload stream.

The endpoint signals that data is waiting in one of two ways. In CPU mode it raises a level interrupt. In DMA mode it raises a DMA request, and the interrupt is then kept for error conditions only.

The link side cannot be stalled, because isochronous traffic has no retry. The link interface therefore has no ready signal. Back-pressure there takes the form of dropping a whole packet, which is recorded as an overrun. The unload stream follows normal valid/ready rules:
- A byte moves on a cycle where both `rd_valid` and `rd_ready` are high.
- While `rd_ready` is low, `rd_valid` and `rd_data` hold.
- `rd_valid` falls once every byte of the head packet has been taken.

Top module: `iso_rx_ep`

## Requirements

The control word uses these bits:

| Bit | Access | Meaning |
|-----|--------|---------|
| 0 | read; write 0 releases the head packet | packet ready |
| 1 | read; write 0 clears | sticky overrun |
| 2 | read; write 0 clears | sticky CRC error |
| 11, 12 | ignored on write | always read as 0 |
| 13 | read/write | DMA enable |
| 14 | read/write | isochronous enable |
| 15 | read/write | auto-clear |

- R1: After reset the control word reads 0, `rx_count`, `irq`, `dma_req` and `rd_valid` are 0, and the max-packet register holds MAX_PKT.
- R2: A packet accepted from the link sets bit 0 on the edge of its last beat. `rx_count` then shows its byte count, and its bytes leave the unload stream in arrival order.
- R3: With `cfg_dbl` low, a packet that starts while one packet is held is dropped whole. The held packet and its count are unchanged, and bit 1 is set.
- R4: With `cfg_dbl` high, two packets are held. Releasing the head packet leaves bit 0 set, and `rx_count` shows the second packet's length.
- R5: With `cfg_dbl` high and two packets held, a third packet is dropped and bit 1 is set.
- R6: A packet with `lnk_crc_err` on any beat is still stored and unloaded normally, and bit 2 is set.
- R7: Writing 0 to bit 0 releases the head packet. Writing 1 to bit 0 has no effect. Writing 0 to bit 1 or bit 2 clears that flag.
- R8: `dma_req` is high exactly while bit 13 is set and a packet is held.
- R9: `irq` is high when a flag (bit 1 or bit 2) is set, or when a packet is held while bit 13 is clear. A held packet in DMA mode raises no interrupt.
- R10: With bit 15 set and bit 13 clear, reading the last byte of a packet whose length equals the max-packet register releases that packet without a write. A shorter packet stays held after it is read.
- R11: Bits 12 and 11 are ignored on write and always read as 0.
- R12: While bit 14 is clear, link beats are ignored and no packet is stored.
- R13: While `rd_ready` is low, `rd_valid` and `rd_data` hold their values. `rd_valid` is low once all bytes of the head packet have been read.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dbl | input | 1 | Double-buffer enable (two packet slots) |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| ctrl_rdata | output | 16 | Control/status word |
| maxp_wr | input | 1 | Max-packet register write strobe |
| maxp_wdata | input | LEN_W (7) | Max-packet size in bytes |
| rx_count | output | LEN_W (7) | Byte count of the head packet, 0 when empty |
| lnk_valid | input | 1 | Link byte beat valid |
| lnk_data | input | DW (8) | Link byte |
| lnk_last | input | 1 | Beat is the last of its packet |
| lnk_crc_err | input | 1 | CRC error reported for the packet |
| rd_valid | output | 1 | Unload stream byte available |
| rd_ready | input | 1 | Unload stream consumer ready |
| rd_data | output | DW (8) | Unload stream byte |
| irq | output | 1 | Endpoint interrupt (level) |
| dma_req | output | 1 | DMA request (level) |

## Verification

Packets of different lengths and byte seeds go through the scoreboard. This shows that ordering and slot selection are correct, and that a dropped packet never leaks into the stream.

The capacity cases are covered in both buffer modes:
- a second packet while in single mode;
- a third packet while in double mode.

Each shows whether capacity follows `cfg_dbl`.

Auto-clear is tried with a packet of exactly max-packet length and with a shorter one, which separates the length match from any read completion. DMA mode is tried with a clean packet and with a CRC-flagged packet, which separates completion interrupts from error interrupts.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
  // control/status word bit positions
  localparam int CTL_RDY  = 0;
  localparam int CTL_OVR  = 1;
  localparam int CTL_CRC  = 2;
  localparam int CTL_DMA  = 13;
  localparam int CTL_ISO  = 14;
  localparam int CTL_ACLR = 15;

  typedef struct packed {
    logic aclr;
    logic iso;
    logic dma;
  } ep_mode_t;
endpackage

// File: rtl/iso_rx_buf.sv
module iso_rx_buf #(
  parameter int NSLOT   = 2,
  parameter int MAX_PKT = 64,
  parameter int DW      = 8,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int IDX_W  = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DW-1:0]     wdata,
  input  logic [SLOT_W-1:0] rslot,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] slot_rd [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [DW-1:0] mem [MAX_PKT];
    always_ff @(posedge clk) begin
      if (we && wslot == SLOT_W'(s)) mem[widx] <= wdata;
    end
    assign slot_rd[s] = mem[ridx];
  end

  assign rdata = slot_rd[rslot];
endmodule

// File: rtl/iso_rx_slot_q.sv
module iso_rx_slot_q #(
  parameter int NSLOT = 2,
  parameter int LEN_W = 7,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CNT_W  = $clog2(NSLOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbl,
  input  logic              push,
  input  logic [LEN_W-1:0]  push_len,
  input  logic              pop,
  output logic              full,
  output logic              empty,
  output logic [SLOT_W-1:0] head,
  output logic [SLOT_W-1:0] tail,
  output logic [LEN_W-1:0]  head_len
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cap;
  logic [LEN_W-1:0] len_q [NSLOT];

  function automatic logic [SLOT_W-1:0] nxt(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(NSLOT - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap   = dbl ? CNT_W'(NSLOT) : CNT_W'(1);
  assign full  = count >= cap;
  assign empty = count == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      head  <= '0;
      tail  <= '0;
    end else begin
      if (push) tail <= nxt(tail);
      if (pop)  head <= nxt(head);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_len
    always_ff @(posedge clk) begin
      if (!rst_n) len_q[s] <= '0;
      else if (push && tail == SLOT_W'(s)) len_q[s] <= push_len;
    end
  end

  assign head_len = empty ? '0 : len_q[head];
endmodule

// File: rtl/iso_rx_ep.sv
module iso_rx_ep
  import iso_rx_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int DW      = 8,
  parameter int NSLOT   = 2,
  localparam int LEN_W  = $clog2(MAX_PKT + 1),
  localparam int IDX_W  = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dbl,
  input  logic             cfg_wr,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      ctrl_rdata,
  input  logic             maxp_wr,
  input  logic [LEN_W-1:0] maxp_wdata,
  output logic [LEN_W-1:0] rx_count,
  input  logic             lnk_valid,
  input  logic [DW-1:0]    lnk_data,
  input  logic             lnk_last,
  input  logic             lnk_crc_err,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [DW-1:0]    rd_data,
  output logic             irq,
  output logic             dma_req
);
  localparam logic [LEN_W-1:0] MAXP_L = LEN_W'(MAX_PKT);

  ep_mode_t         mode;
  logic [LEN_W-1:0] maxp;
  logic             ovr_flag, crc_flag;

  // receive capture state
  logic             rx_busy, rx_keep, rx_crc;
  logic [LEN_W-1:0] wr_idx;

  // queue interface
  logic              q_full, q_empty, q_push, q_pop;
  logic [SLOT_W-1:0] q_head, q_tail;
  logic [LEN_W-1:0]  q_head_len, push_len;

  // unload side
  logic [LEN_W-1:0] rd_ptr;
  logic             rd_fire, sw_pop, auto_pop;

  // receive path
  logic beat, keep_now, wr_en, ovr_set, room;
  assign beat     = lnk_valid && mode.iso;
  assign keep_now = rx_busy ? rx_keep : !q_full;
  assign room     = wr_idx < MAXP_L;
  assign wr_en    = beat && keep_now && room;
  assign push_len = room ? wr_idx + 1'b1 : wr_idx;
  assign q_push   = beat && lnk_last && keep_now;
  assign ovr_set  = beat && lnk_last && !keep_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_busy <= 1'b0;
      rx_keep <= 1'b0;
      rx_crc  <= 1'b0;
      wr_idx  <= '0;
    end else if (beat) begin
      if (lnk_last) begin
        rx_busy <= 1'b0;
        rx_crc  <= 1'b0;
        wr_idx  <= '0;
      end else begin
        rx_busy <= 1'b1;
        rx_keep <= keep_now;
        rx_crc  <= rx_crc | lnk_crc_err;
        wr_idx  <= push_len;
      end
    end
  end

  // register block
  wire unused_bits = ^{cfg_wdata[12:3]};

  assign sw_pop = cfg_wr && !cfg_wdata[CTL_RDY] && !q_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= '0;
      maxp     <= MAXP_L;
      ovr_flag <= 1'b0;
      crc_flag <= 1'b0;
    end else begin
      if (cfg_wr) begin
        mode.aclr <= cfg_wdata[CTL_ACLR];
        mode.iso  <= cfg_wdata[CTL_ISO];
        mode.dma  <= cfg_wdata[CTL_DMA];
      end
      if (maxp_wr) maxp <= maxp_wdata;
      if (ovr_set) ovr_flag <= 1'b1;
      else if (cfg_wr && !cfg_wdata[CTL_OVR]) ovr_flag <= 1'b0;
      if (q_push && (rx_crc || lnk_crc_err)) crc_flag <= 1'b1;
      else if (cfg_wr && !cfg_wdata[CTL_CRC]) crc_flag <= 1'b0;
    end
  end

  // unload path
  assign rd_valid = !q_empty && (rd_ptr < q_head_len);
  assign rd_fire  = rd_valid && rd_ready;
  assign auto_pop = rd_fire && mode.aclr && !mode.dma &&
                    (q_head_len == maxp) && (rd_ptr == q_head_len - 1'b1);
  assign q_pop    = sw_pop || auto_pop;

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_ptr <= '0;
    else if (q_pop)   rd_ptr <= '0;
    else if (rd_fire) rd_ptr <= rd_ptr + 1'b1;
  end

  iso_rx_slot_q #(.NSLOT(NSLOT), .LEN_W(LEN_W)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .dbl      (cfg_dbl),
    .push     (q_push),
    .push_len (push_len),
    .pop      (q_pop),
    .full     (q_full),
    .empty    (q_empty),
    .head     (q_head),
    .tail     (q_tail),
    .head_len (q_head_len)
  );

  iso_rx_buf #(.NSLOT(NSLOT), .MAX_PKT(MAX_PKT), .DW(DW)) u_buf (
    .clk   (clk),
    .we    (wr_en),
    .wslot (q_tail),
    .widx  (wr_idx[IDX_W-1:0]),
    .wdata (lnk_data),
    .rslot (q_head),
    .ridx  (rd_ptr[IDX_W-1:0]),
    .rdata (rd_data)
  );

  // outputs
  always_comb begin
    ctrl_rdata           = '0;
    ctrl_rdata[CTL_RDY]  = !q_empty;
    ctrl_rdata[CTL_OVR]  = ovr_flag;
    ctrl_rdata[CTL_CRC]  = crc_flag;
    ctrl_rdata[CTL_DMA]  = mode.dma;
    ctrl_rdata[CTL_ISO]  = mode.iso;
    ctrl_rdata[CTL_ACLR] = mode.aclr;
  end

  assign rx_count = q_head_len;
  assign dma_req  = mode.dma && !q_empty;
  assign irq      = ovr_flag || crc_flag || (!mode.dma && !q_empty);
endmodule

// File: rtl/iso_rx_ep_chk.sv
module iso_rx_ep_chk #(
  parameter int DW    = 8,
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [15:0]      ctrl_rdata,
  input logic [LEN_W-1:0] rx_count,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [DW-1:0]    rd_data,
  input logic             irq,
  input logic             dma_req
);
  // R8
  dma_needs_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (ctrl_rdata[13] && ctrl_rdata[0]));

  // R9
  dma_quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[13] && !ctrl_rdata[1] && !ctrl_rdata[2]) |-> !irq);

  // R3
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[1] && !cfg_wr) |=> ctrl_rdata[1]);

  // R6
  crc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[2] && !cfg_wr) |=> ctrl_rdata[2]);

  // R13
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !cfg_wr) |=> (rd_valid && $stable(rd_data)));

  // R2
  rd_needs_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (ctrl_rdata[0] && rx_count != '0));

  // R11
  ignored_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[12:11] == 2'b00);
endmodule

bind iso_rx_ep iso_rx_ep_chk #(.DW(DW), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .ctrl_rdata (ctrl_rdata),
  .rx_count   (rx_count),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .irq        (irq),
  .dma_req    (dma_req)
);

// File: tb/iso_rx_ep_bench.sv
`timescale 1ns/1ps
module iso_rx_ep_bench;
  localparam int MAX_PKT = 64;
  localparam int DW      = 8;
  localparam int LEN_W   = $clog2(MAX_PKT + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_dbl = 1'b0;
  logic             cfg_wr = 1'b0;
  logic [15:0]      cfg_wdata = '0;
  logic [15:0]      ctrl_rdata;
  logic             maxp_wr = 1'b0;
  logic [LEN_W-1:0] maxp_wdata = '0;
  logic [LEN_W-1:0] rx_count;
  logic             lnk_valid = 1'b0;
  logic [DW-1:0]    lnk_data = '0;
  logic             lnk_last = 1'b0;
  logic             lnk_crc_err = 1'b0;
  logic             rd_valid;
  logic             rd_ready = 1'b0;
  logic [DW-1:0]    rd_data;
  logic             irq, dma_req;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q [$];

  always #2 clk = ~clk;

  iso_rx_ep #(.MAX_PKT(MAX_PKT), .DW(DW)) u_iso_rx_ep (
    .clk(clk), .rst_n(rst_n), .cfg_dbl(cfg_dbl), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .ctrl_rdata(ctrl_rdata), .maxp_wr(maxp_wr),
    .maxp_wdata(maxp_wdata), .rx_count(rx_count), .lnk_valid(lnk_valid),
    .lnk_data(lnk_data), .lnk_last(lnk_last), .lnk_crc_err(lnk_crc_err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .irq(irq), .dma_req(dma_req)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compare every unloaded byte against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected byte", int'(rd_data), 0);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R2 byte order", int'(rd_data), int'(e));
      end
    end
  end

  task automatic wr_ctrl(input logic [15:0] v);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_pkt(input int len, input logic crc, input int seed, input logic push);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      lnk_valid   = 1'b1;
      lnk_data    = DW'(seed + i);
      lnk_last    = (i == len - 1);
      lnk_crc_err = crc && (i == 0);
      if (push) exp_q.push_back(DW'(seed + i));
    end
    @(posedge clk); #1;
    lnk_valid = 1'b0; lnk_last = 1'b0; lnk_crc_err = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_bytes(input int n);
    int got = 0;
    @(posedge clk); #1;
    rd_ready = 1'b1;
    for (int k = 0; k < 4 * n + 8; k++) begin
      @(negedge clk);
      if (rd_valid) got++;
      if (got == n) break;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    rd_ready = 1'b0;
    @(negedge clk);
    check(got == n, "R13 read count", got, n);
  endtask

  localparam logic [15:0] ISO = 16'h4000;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ctrl_rdata == 16'h0, "R1 ctrl", ctrl_rdata, 0);
    check(rx_count == 0 && !irq && !dma_req && !rd_valid, "R1 outs",
          {rx_count, irq, dma_req, rd_valid}, 0);

    wr_ctrl(ISO | 16'h0007);
    // R2 basic packet
    send_pkt(5, 1'b0, 8'h10, 1'b1);
    check(ctrl_rdata[0] == 1'b1, "R2 ready", ctrl_rdata[0], 1);
    check(rx_count == 5, "R2 count", rx_count, 5);
    check(irq && !dma_req, "R9 cpu irq", {irq, dma_req}, 2'b10);
    read_bytes(5);
    check(!rd_valid, "R13 drained", rd_valid, 0);
    check(ctrl_rdata[0], "R10 no autoclr", ctrl_rdata[0], 1);
    // R7 writing 1 to ready has no effect
    wr_ctrl(ISO | 16'h0007);
    check(ctrl_rdata[0], "R7 write one", ctrl_rdata[0], 1);
    wr_ctrl(ISO | 16'h0006);
    check(!ctrl_rdata[0] && !irq, "R7 release", {ctrl_rdata[0], irq}, 0);

    // R3 single buffer overrun
    send_pkt(3, 1'b0, 8'h20, 1'b1);
    send_pkt(4, 1'b0, 8'h40, 1'b0);
    check(ctrl_rdata[1], "R3 ovr", ctrl_rdata[1], 1);
    check(rx_count == 3, "R3 count", rx_count, 3);
    read_bytes(3);
    wr_ctrl(ISO | 16'h0006);
    check(!ctrl_rdata[0], "R3 dropped gone", ctrl_rdata[0], 0);
    wr_ctrl(ISO | 16'h0005);
    check(!ctrl_rdata[1] && !irq, "R7 ovr clear", {ctrl_rdata[1], irq}, 0);

    // R4 / R5 double buffer
    cfg_dbl = 1'b1;
    send_pkt(4, 1'b0, 8'h50, 1'b1);
    send_pkt(6, 1'b0, 8'h60, 1'b1);
    check(!ctrl_rdata[1], "R4 two held", ctrl_rdata[1], 0);
    send_pkt(2, 1'b0, 8'h70, 1'b0);
    check(ctrl_rdata[1], "R5 ovr", ctrl_rdata[1], 1);
    check(rx_count == 4, "R4 head count", rx_count, 4);
    read_bytes(4);
    wr_ctrl(ISO | 16'h0006);
    check(ctrl_rdata[0] && rx_count == 6, "R4 second", rx_count, 6);
    read_bytes(6);
    wr_ctrl(ISO | 16'h0004);
    check(ctrl_rdata[2:0] == 3'b000, "R4 empty", ctrl_rdata[2:0], 0);

    // R6 crc error packet
    send_pkt(3, 1'b1, 8'h80, 1'b1);
    check(ctrl_rdata[2] && rx_count == 3, "R6 crc", {ctrl_rdata[2], rx_count}, {1'b1, 7'd3});
    read_bytes(3);
    wr_ctrl(ISO | 16'h0002);
    check(ctrl_rdata[2:0] == 3'b000, "R7 crc clear", ctrl_rdata[2:0], 0);

    // R8 / R9 DMA mode
    wr_ctrl(16'h6007);
    send_pkt(2, 1'b0, 8'h90, 1'b1);
    check(dma_req && !irq, "R8 dma req", {dma_req, irq}, 2'b10);
    send_pkt(2, 1'b1, 8'hA0, 1'b1);
    check(irq, "R9 dma err irq", irq, 1);
    read_bytes(2);
    wr_ctrl(16'h6006);
    read_bytes(2);
    wr_ctrl(16'h6002);
    check(!dma_req && !irq, "R8 dma idle", {dma_req, irq}, 0);

    // R10 auto-clear
    @(posedge clk); #1 maxp_wr = 1'b1; maxp_wdata = 7'd8;
    @(posedge clk); #1 maxp_wr = 1'b0;
    wr_ctrl(16'hC007);
    send_pkt(8, 1'b0, 8'hB0, 1'b1);
    read_bytes(8);
    check(!ctrl_rdata[0], "R10 autoclr full", ctrl_rdata[0], 0);
    send_pkt(5, 1'b0, 8'hC0, 1'b1);
    read_bytes(5);
    check(ctrl_rdata[0], "R10 short held", ctrl_rdata[0], 1);
    wr_ctrl(16'hC006);

    // R11 ignored bits
    wr_ctrl(16'h5807);
    check(ctrl_rdata[12:11] == 2'b00, "R11 readback", ctrl_rdata[12:11], 0);
    send_pkt(3, 1'b0, 8'hD0, 1'b1);
    check(irq && !dma_req, "R11 no effect", {irq, dma_req}, 2'b10);
    // R13 hold under back-pressure
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rd_valid && rd_data == 8'hD0, "R13 hold", rd_data, 8'hD0);
    read_bytes(3);
    wr_ctrl(ISO | 16'h0006);

    // R12 iso off
    wr_ctrl(16'h0007);
    send_pkt(4, 1'b0, 8'hE0, 1'b0);
    check(!ctrl_rdata[0] && !rd_valid, "R12 ignored", ctrl_rdata[0], 0);

    check(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule